// File: doc/BRIEF.md
# Four-Mode Addressable Bit Latch

This block keeps a bank of single-bit storage cells, eight by default, and drives one active-low output per cell. The outputs model the gates of open-drain drivers: a low output means the driver conducts. Every output is therefore the inverse of the bit that is stored in its cell or routed to it. A binary select code picks one cell, and a serial data bit is the value that is written or routed.

Two active-low control inputs, `clr_n` and `en_n`, choose one of four modes. In LATCH mode the selected cell takes the data bit and the other cells keep theirs. In HOLD mode nothing changes. In DEMUX mode the selected cell takes the data bit and every other cell is cleared. In CLEAR mode every cell is cleared. All updates are made on the rising edge of `clk`, so an output follows its inputs one cycle later. A synchronous reset clears every cell. Callers should hold `en_n` high while the select code changes, so that no wrong cell is written during the change.

The mode decoder has no state of its own. Each cell is a two-state machine, with states CLEARED (bit 0, output high) and SET (bit 1, output low). The transitions are named as follows. WRITE moves the selected cell to the state of `din` in LATCH or DEMUX mode. KEEP leaves any cell in its state in HOLD mode, and leaves an unselected cell in its state in LATCH mode. WIPE moves a cell to CLEARED in three cases: in CLEAR mode, for an unselected cell in DEMUX mode, and on reset.

Top module: `addr_latch8`

## Requirements
- R1: While `rst` is high at a rising edge, every cell is cleared. From the next cycle on, `drv_n` reads all ones.
- R2: In LATCH mode (`clr_n`=1, `en_n`=0), the cell picked by `sel` takes `din`. After the edge, its output reads `~din`.
- R3: In LATCH mode, every output not picked by `sel` keeps its previous value.
- R4: In HOLD mode (`clr_n`=1, `en_n`=1), all outputs keep their previous values whatever `din` and `sel` are.
- R5: In DEMUX mode (`clr_n`=0, `en_n`=0), the picked output reads `~din` and every other output reads 1.
- R6: DEMUX mode clears the cells it does not pick. After a later switch to HOLD mode, those outputs stay high and the picked output keeps the value it showed.
- R7: In CLEAR mode (`clr_n`=0, `en_n`=1), all outputs read 1 whatever `din` and `sel` are, and they stay at 1 in a following HOLD mode.
- R8: `sel` is an unsigned binary number with its MSB at bit 2. Value 0 picks `drv_n[0]` and value 7 picks `drv_n[7]`.
- R9: Outputs are active low. A stored 1 gives a 0 on its `drv_n` bit, and a stored 0 gives a 1.
- R10: Inputs take effect at the first rising edge at which they are sampled. Before that edge, `drv_n` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Data bit to write or route |
| sel | input | 3 | Cell select code, binary |
| clr_n | input | 1 | Clear control, active low |
| en_n | input | 1 | Enable control, active low |
| drv_n | output | 8 | Driver gate outputs, active low |

## Verification
The bench targets four places where the modes interact. The first is the switch from DEMUX to HOLD. A design that only masks the unpicked outputs, instead of clearing their cells, would bring stale low outputs back at that point. The second is the two ends of the select code, where a reversed or misdecoded select would drive the wrong end of the bank. The third is CLEAR and HOLD with live data and select inputs, where a leaky write path would change an output that must not move. The fourth is reset in the middle of a run, which must wipe cells that were set. A long random run with a reference model holds `en_n` high around every select change and checks all eight outputs on every cycle, which catches inverted polarity and wrong latency.

// File: rtl/al_pkg.sv
package al_pkg;

    // Mode encoding is {clr_n, en_n}
    typedef enum logic [1:0] {
        M_DEMUX = 2'b00,
        M_CLEAR = 2'b01,
        M_LATCH = 2'b10,
        M_HOLD  = 2'b11
    } mode_t;

endpackage

// File: rtl/al_mode_decode.sv
module al_mode_decode
    import al_pkg::*;
(
    input  logic  clr_n,
    input  logic  en_n,
    output mode_t mode
);

    always_comb begin
        unique case ({clr_n, en_n})
            2'b00:   mode = M_DEMUX;
            2'b01:   mode = M_CLEAR;
            2'b10:   mode = M_LATCH;
            default: mode = M_HOLD;
        endcase
    end

endmodule

// File: rtl/al_sel_decode.sv
module al_sel_decode #(
    parameter int NCELL = 8,
    parameter int SEL_W = $clog2(NCELL)
) (
    input  logic [SEL_W-1:0] sel,
    output logic [NCELL-1:0] hit
);

    always_comb begin
        for (int i = 0; i < NCELL; i++) begin
            hit[i] = (sel == SEL_W'(i));
        end
    end

endmodule

// File: rtl/al_cell.sv
module al_cell
    import al_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_t mode,
    input  logic  hit,
    input  logic  din,
    output logic  q
);

    // Cell state: CLEARED (q=0) or SET (q=1)
    logic q_nxt;

    always_comb begin
        unique case (mode)
            M_LATCH: q_nxt = hit ? din : q;    // WRITE or KEEP
            M_HOLD:  q_nxt = q;                // KEEP
            M_DEMUX: q_nxt = hit ? din : 1'b0; // WRITE or WIPE
            M_CLEAR: q_nxt = 1'b0;             // WIPE
            default: q_nxt = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= q_nxt;
    end

endmodule

// File: rtl/addr_latch8.sv
module addr_latch8
    import al_pkg::*;
#(
    parameter int NCELL = 8,
    parameter int SEL_W = $clog2(NCELL)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  logic [SEL_W-1:0] sel,
    input  logic             clr_n,
    input  logic             en_n,
    output logic [NCELL-1:0] drv_n
);

    mode_t            mode;
    logic [NCELL-1:0] hit;
    logic [NCELL-1:0] cells;

    al_mode_decode u_mode (
        .clr_n (clr_n),
        .en_n  (en_n),
        .mode  (mode)
    );

    al_sel_decode #(.NCELL(NCELL), .SEL_W(SEL_W)) u_sel (
        .sel (sel),
        .hit (hit)
    );

    for (genvar g = 0; g < NCELL; g++) begin : g_cell
        al_cell u_cell (
            .clk  (clk),
            .rst  (rst),
            .mode (mode),
            .hit  (hit[g]),
            .din  (din),
            .q    (cells[g])
        );
    end

    always_comb drv_n = ~cells;

endmodule

// File: rtl/al_chk.sv
module al_chk #(
    parameter int NCELL = 8,
    parameter int SEL_W = $clog2(NCELL)
) (
    input logic             clk,
    input logic             rst,
    input logic             din,
    input logic [SEL_W-1:0] sel,
    input logic             clr_n,
    input logic             en_n,
    input logic [NCELL-1:0] drv_n
);

    localparam logic [NCELL-1:0] ONE  = NCELL'(1);
    localparam logic [NCELL-1:0] HIGH = {NCELL{1'b1}};

    // R1
    reset_high_chk: assert property (@(posedge clk)
        rst |=> drv_n == HIGH);

    // R2
    latch_write_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_n && !en_n) |=> drv_n[$past(sel)] == !$past(din));

    // R3
    latch_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_n && !en_n) |=> ((drv_n ^ $past(drv_n)) & ~(ONE << $past(sel))) == '0);

    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_n && en_n) |=> $stable(drv_n));

    // R5
    demux_route_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr_n && !en_n) |=> drv_n == ~(NCELL'($past(din)) << $past(sel)));

    // R7
    clear_all_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr_n && en_n) |=> drv_n == HIGH);

endmodule

bind addr_latch8 al_chk #(.NCELL(NCELL), .SEL_W(SEL_W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .din   (din),
    .sel   (sel),
    .clr_n (clr_n),
    .en_n  (en_n),
    .drv_n (drv_n)
);

// File: tb/sim_addr_latch8.sv
module sim_addr_latch8;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 15;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       din = 1'b0;
    logic [2:0] sel = 3'd0;
    logic       clr_n = 1'b1;
    logic       en_n = 1'b1;
    logic [7:0] drv_n;

    int total = 0;
    int bad = 0;

    addr_latch8 u0 (
        .clk   (clk),
        .rst   (rst),
        .din   (din),
        .sel   (sel),
        .clr_n (clr_n),
        .en_n  (en_n),
        .drv_n (drv_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Each vector is {clr_n, en_n, sel[2:0], din, expected drv_n[7:0]}
    localparam logic [13:0] VEC [NVEC] = '{
        {2'b10, 3'd0, 1'b1, 8'hFE},  // R2 R8 R9: select 0 -> bit 0 low
        {2'b10, 3'd7, 1'b1, 8'h7E},  // R2 R8: select 7 -> bit 7
        {2'b11, 3'd3, 1'b1, 8'h7E},  // R4
        {2'b10, 3'd0, 1'b0, 8'h7F},  // R2 R3
        {2'b10, 3'd3, 1'b1, 8'h77},  // R3
        {2'b11, 3'd5, 1'b0, 8'h77},  // R4
        {2'b00, 3'd2, 1'b1, 8'hFB},  // R5
        {2'b11, 3'd6, 1'b1, 8'hFB},  // R6
        {2'b00, 3'd5, 1'b0, 8'hFF},  // R5
        {2'b10, 3'd4, 1'b1, 8'hEF},  // R2
        {2'b01, 3'd4, 1'b1, 8'hFF},  // R7
        {2'b11, 3'd0, 1'b1, 8'hFF},  // R7
        {2'b10, 3'd6, 1'b1, 8'hBF},  // R2
        {2'b00, 3'd6, 1'b1, 8'hBF},  // R5
        {2'b10, 3'd1, 1'b1, 8'hBD}   // R3
    };

    task automatic check(input logic [7:0] exp, input string req);
        total++;
        if (drv_n !== exp) begin
            bad++;
            $display("FAIL %s: drv_n=%h expected=%h", req, drv_n, exp);
        end
    endtask

    // Drive at a falling edge, pass one rising edge, return at the next falling edge
    task automatic step(input logic c, input logic e, input logic [2:0] s, input logic d);
        clr_n = c; en_n = e; sel = s; din = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: run did not end, expected end before timeout");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] model;
        logic [2:0] cur_sel;
        @(negedge clk);
        step(1'b1, 1'b1, 3'd0, 1'b0);
        step(1'b1, 1'b1, 3'd0, 1'b0);
        rst = 1'b0;
        check(8'hFF, "R1");

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][13], VEC[i][12], VEC[i][11:9], VEC[i][8]);
            check(VEC[i][7:0], $sformatf("R2-vector%0d", i));
        end

        // R6: demux then hold keeps only the picked output low
        step(1'b0, 1'b0, 3'd3, 1'b1);
        step(1'b1, 1'b1, 3'd3, 1'b0);
        check(8'hF7, "R6");

        // R10: no change before the sampling edge
        clr_n = 1'b1; en_n = 1'b0; sel = 3'd0; din = 1'b1;
        #1;
        check(8'hF7, "R10");
        @(posedge clk);
        @(negedge clk);
        check(8'hF6, "R10");

        // R1: reset in mid-run while latch-mode inputs are live
        rst = 1'b1;
        step(1'b1, 1'b0, 3'd5, 1'b1);
        rst = 1'b0;
        check(8'hFF, "R1");

        // R4 R7: hold and clear ignore data and select
        step(1'b1, 1'b0, 3'd7, 1'b1);
        step(1'b1, 1'b1, 3'd2, 1'b1);
        check(8'h7F, "R4");
        step(1'b0, 1'b1, 3'd7, 1'b0);
        check(8'hFF, "R7");

        // Random run with a reference model; en_n held high across select changes
        model = 8'h00;
        cur_sel = 3'd0;
        for (int n = 0; n < 600; n++) begin
            logic [2:0] ns;
            logic       nd;
            logic [1:0] m;
            ns = 3'($urandom_range(0, 7));
            nd = 1'($urandom_range(0, 1));
            m  = 2'($urandom_range(0, 3));
            if (ns != cur_sel) begin
                step(1'b1, 1'b1, ns, nd);
                cur_sel = ns;
                check(~model, "R4");
            end
            step(m[1], m[0], cur_sel, nd);
            unique case (m)
                2'b10: model[cur_sel] = nd;
                2'b11: model = model;
                2'b00: begin model = 8'h00; model[cur_sel] = nd; end
                default: model = 8'h00;
            endcase
            check(~model, "R9");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule